// File: doc/BRIEF.md
# Control Transfer Stage Tracker

This block follows the endpoint-0 control transfer of a USB device through its stages. It watches decoded token strobes (SETUP, IN, OUT, PING), received data packets with their data PID, and the two handshake strobes: ACK sent by the device and ACK received from the host. It also reads the request direction and whether the requested length is zero, both decoded from the setup packet elsewhere. From these events it keeps a 3-bit stage code and raises a STALL request when the host breaks the expected sequence.

Five interrupt causes record stage transitions. Each cause has a sticky status bit that software clears by writing a one, and an enable bit that gates it onto the single interrupt line. A sequence error keeps the stage code at the error value until software clears the error status. A setup stage that completes while the error is held is remembered. Its interrupt, and its move into the new data or status stage, take effect only after the clear.

Top module: `ctl_stage_tracker`

## Requirements
- R1: After reset, stage is 000, stall_req is 0 and all status bits are 0. Stage codes are: 000 idle/setup, 001 read data, 010 read status, 011 write data, 100 write status, 101 no-data status, 110 sequence error. The code 111 never appears.
- R2: A SETUP token puts the stage at 000. The next ACK-sent then sets status bit 0 (setup done) and moves the stage to 101 if req_len_zero=1, to 001 if req_dir_in=1, and to 011 otherwise. Direction and length are sampled on that ACK.
- R3: In 001, an OUT or PING token after at least one ACK received moves the stage to 010 and sets status bit 1. In 011, an IN token after at least one ACK sent moves the stage to 100 and sets status bit 2.
- R4: The stage returns to 000 and status bit 3 (complete) is set on ACK sent in 010, and on ACK received in 100 or 101.
- R5: In a control read, each of these is a sequence error: OUT or PING in 001 before any ACK received; IN in 010; a DATA0 packet (pkt_pid1=0) in 010.
- R6: In a control write, each of these is a sequence error: IN in 011 before any ACK sent; a first data packet with DATA0 in 011; OUT or PING in 100.
- R7: OUT or PING in 101 is a sequence error.
- R8: A sequence error moves the stage to 110, raises stall_req and sets status bit 4, all on the same clock edge.
- R9: Stage 110 holds until cause_clr bit 4 is written. The clear then moves the stage to 000 on the next edge. If a setup stage completed (SETUP then ACK sent) during the hold, the clear instead moves the stage to that setup's destination and sets status bit 0; bit 0 is not set before the clear.
- R10: In 011, data packets after the first are accepted with either PID, and any number of them raise no error.
- R11: In 010, a DATA1 packet of any length causes no error and the following ACK sent completes the transfer normally.
- R12: A SETUP token in any stage aborts the transfer: stage goes to 000 (or stays 110 while an error is held) and stall_req drops on the next edge.
- R13: Status bits are sticky. A one in cause_clr clears a bit, and a new event on the same edge wins. irq is the OR of the status bits masked by cause_en, and the enables do not alter the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_setup | input | 1 | SETUP token strobe |
| tok_in | input | 1 | IN token strobe |
| tok_out | input | 1 | OUT token strobe |
| tok_ping | input | 1 | PING token strobe |
| pkt_rx | input | 1 | Data packet received strobe |
| pkt_pid1 | input | 1 | Data PID of received packet, 1 = DATA1, 0 = DATA0 |
| hs_ack_sent | input | 1 | Device sent ACK |
| hs_ack_rcvd | input | 1 | Device received ACK |
| req_dir_in | input | 1 | Request direction, 1 = device to host |
| req_len_zero | input | 1 | Requested length is zero |
| cause_en | input | 5 | Interrupt enables, bit order as status |
| cause_clr | input | 5 | Write-one-to-clear strobes for status |
| stage | output | 3 | Current stage code |
| stall_req | output | 1 | Endpoint must answer STALL |
| cause_sts | output | 5 | Status: 0 setup done, 1 read status entry, 2 write status entry, 3 complete, 4 sequence error |
| irq | output | 1 | Interrupt request |

## Verification
The bench covers every listed error trigger, each just before and just after the condition that makes it legal. A design that counted the wrong handshake would then stall good transfers or miss bad ones. The bench aims at the deferred setup while an error is held. A design that dropped the setup would go to idle after the clear, and one that did not defer it would leave 110 early or raise setup done before the clear. It also drives DATA0 packets after the first write packet, DATA1 data in the read status stage, and SETUP in the middle of a transfer. A design that flagged extra data, checked packet length or kept the stall after an abort would diverge from the model.

// File: rtl/ctl_stage_pkg.sv
package ctl_stage_pkg;
  localparam int STAGE_W = 3;
  localparam int NCAUSE  = 5;

  localparam int C_SETUP  = 0;
  localparam int C_RDSTAT = 1;
  localparam int C_WRSTAT = 2;
  localparam int C_DONE   = 3;
  localparam int C_ERR    = 4;

  typedef enum logic [STAGE_W-1:0] {
    ST_IDLE    = 3'b000,
    ST_RD_DATA = 3'b001,
    ST_RD_STAT = 3'b010,
    ST_WR_DATA = 3'b011,
    ST_WR_STAT = 3'b100,
    ST_ND_STAT = 3'b101,
    ST_SEQ_ERR = 3'b110
  } stage_e;

  typedef struct packed {
    logic setup;
    logic tin;
    logic tout;
    logic tping;
    logic drx;
    logic pid1;
    logic ack_tx;
    logic ack_rx;
  } bus_ev_t;
endpackage

// File: rtl/ctl_seq_fsm.sv
module ctl_seq_fsm
  import ctl_stage_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  bus_ev_t           ev,
  input  logic              dir_in,
  input  logic              len_zero,
  input  logic              err_clr,
  output stage_e            stage,
  output logic              stall,
  output logic [NCAUSE-1:0] cause
);
  stage_e stage_q, stage_n, dst_q, dst_n, dest;
  logic   hs_q, hs_n;
  logic   moved_q, moved_n;
  logic   first_q, first_n;
  logic   defer_q, defer_n;
  logic   stall_q, stall_n;
  logic   go_err;
  logic   tok_outp;
  logic [NCAUSE-1:0] cause_n;

  assign tok_outp = ev.tout | ev.tping;
  assign dest = len_zero ? ST_ND_STAT : (dir_in ? ST_RD_DATA : ST_WR_DATA);

  always_comb begin
    stage_n = stage_q;
    dst_n   = dst_q;
    hs_n    = hs_q;
    moved_n = moved_q;
    first_n = first_q;
    defer_n = defer_q;
    stall_n = stall_q;
    cause_n = '0;
    go_err  = 1'b0;
    if (ev.setup) begin
      hs_n    = 1'b1;
      stall_n = 1'b0;
      defer_n = 1'b0;
      if (stage_q != ST_SEQ_ERR) stage_n = ST_IDLE;
    end else if (hs_q && ev.ack_tx) begin
      hs_n    = 1'b0;
      moved_n = 1'b0;
      first_n = 1'b0;
      if (stage_q == ST_SEQ_ERR) begin
        defer_n = 1'b1;
        dst_n   = dest;
      end else begin
        stage_n          = dest;
        cause_n[C_SETUP] = 1'b1;
      end
    end else begin
      unique case (stage_q)
        ST_SEQ_ERR: begin
          if (err_clr) begin
            defer_n          = 1'b0;
            stage_n          = defer_q ? dst_q : ST_IDLE;
            cause_n[C_SETUP] = defer_q;
          end
        end
        ST_RD_DATA: begin
          if (tok_outp) begin
            if (moved_q) begin
              stage_n           = ST_RD_STAT;
              cause_n[C_RDSTAT] = 1'b1;
            end else begin
              go_err = 1'b1;
            end
          end else if (ev.ack_rx) begin
            moved_n = 1'b1;
          end
        end
        ST_RD_STAT: begin
          if (ev.tin || (ev.drx && !ev.pid1)) begin
            go_err = 1'b1;
          end else if (ev.ack_tx) begin
            stage_n         = ST_IDLE;
            cause_n[C_DONE] = 1'b1;
          end
        end
        ST_WR_DATA: begin
          if (ev.tin) begin
            if (moved_q) begin
              stage_n           = ST_WR_STAT;
              cause_n[C_WRSTAT] = 1'b1;
            end else begin
              go_err = 1'b1;
            end
          end else begin
            if (ev.drx) begin
              first_n = 1'b1;
              if (!first_q && !ev.pid1) go_err = 1'b1;
            end
            if (ev.ack_tx) moved_n = 1'b1;
          end
        end
        ST_WR_STAT, ST_ND_STAT: begin
          if (tok_outp) begin
            go_err = 1'b1;
          end else if (ev.ack_rx) begin
            stage_n         = ST_IDLE;
            cause_n[C_DONE] = 1'b1;
          end
        end
        default: ;
      endcase
      if (go_err) begin
        stage_n        = ST_SEQ_ERR;
        stall_n        = 1'b1;
        cause_n[C_ERR] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= ST_IDLE;
      dst_q   <= ST_IDLE;
      hs_q    <= 1'b0;
      moved_q <= 1'b0;
      first_q <= 1'b0;
      defer_q <= 1'b0;
      stall_q <= 1'b0;
    end else begin
      stage_q <= stage_n;
      dst_q   <= dst_n;
      hs_q    <= hs_n;
      moved_q <= moved_n;
      first_q <= first_n;
      defer_q <= defer_n;
      stall_q <= stall_n;
    end
  end

  assign stage = stage_q;
  assign stall = stall_q;
  assign cause = cause_n;

  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    stage_q != 3'b111); // R1
  AST_ERR_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stage_q == ST_SEQ_ERR) |-> stall_q); // R8
  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q == ST_SEQ_ERR && !err_clr) |=> stage_q == ST_SEQ_ERR); // R9
  AST_SETUP_UNSTALLS: assert property (@(posedge clk) disable iff (!rst_n)
    ev.setup |=> !stall_q); // R12
endmodule

// File: rtl/ctl_irq_regs.sv
module ctl_irq_regs #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] en,
  input  logic [N-1:0] clr,
  output logic [N-1:0] status,
  output logic         irq
);
  logic [N-1:0] sts_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic nxt;
    assign nxt = set_ev[i] | (sts_q[i] & ~clr[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts_q[i] <= 1'b0;
      else        sts_q[i] <= nxt;
    end

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q[i] && !clr[i]) |=> sts_q[i]); // R13
    AST_EVENT_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev[i] |=> sts_q[i]); // R13
  end

  assign status = sts_q;
  assign irq    = |(sts_q & en);
endmodule

// File: rtl/ctl_stage_tracker.sv
module ctl_stage_tracker
  import ctl_stage_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_setup,
  input  logic              tok_in,
  input  logic              tok_out,
  input  logic              tok_ping,
  input  logic              pkt_rx,
  input  logic              pkt_pid1,
  input  logic              hs_ack_sent,
  input  logic              hs_ack_rcvd,
  input  logic              req_dir_in,
  input  logic              req_len_zero,
  input  logic [NCAUSE-1:0] cause_en,
  input  logic [NCAUSE-1:0] cause_clr,
  output logic [STAGE_W-1:0] stage,
  output logic              stall_req,
  output logic [NCAUSE-1:0] cause_sts,
  output logic              irq
);
  bus_ev_t           ev;
  stage_e            stage_w;
  logic [NCAUSE-1:0] cause_w;

  assign ev = '{setup: tok_setup, tin: tok_in, tout: tok_out, tping: tok_ping,
                drx: pkt_rx, pid1: pkt_pid1, ack_tx: hs_ack_sent, ack_rx: hs_ack_rcvd};

  ctl_seq_fsm i_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (ev),
    .dir_in   (req_dir_in),
    .len_zero (req_len_zero),
    .err_clr  (cause_clr[C_ERR]),
    .stage    (stage_w),
    .stall    (stall_req),
    .cause    (cause_w)
  );

  ctl_irq_regs #(.N(NCAUSE)) i_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_ev (cause_w),
    .en     (cause_en),
    .clr    (cause_clr),
    .status (cause_sts),
    .irq    (irq)
  );

  assign stage = stage_w;

  AST_ERR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    stage_w == ST_SEQ_ERR |-> cause_sts[C_ERR]); // R8
endmodule

// File: tb/test_ctl_stage_tracker.sv
`timescale 1ns/1ps
module test_ctl_stage_tracker;
  logic clk = 1'b0;
  logic rst_n;
  logic tok_setup, tok_in, tok_out, tok_ping, pkt_rx, pkt_pid1;
  logic hs_ack_sent, hs_ack_rcvd, req_dir_in, req_len_zero;
  logic [4:0] cause_en, cause_clr;
  logic [2:0] stage;
  logic stall_req, irq;
  logic [4:0] cause_sts;

  int total = 0;
  int bad = 0;
  bit live = 0;

  always #2 clk = ~clk;

  ctl_stage_tracker i_ctl_stage_tracker (
    .clk(clk), .rst_n(rst_n), .tok_setup(tok_setup), .tok_in(tok_in),
    .tok_out(tok_out), .tok_ping(tok_ping), .pkt_rx(pkt_rx), .pkt_pid1(pkt_pid1),
    .hs_ack_sent(hs_ack_sent), .hs_ack_rcvd(hs_ack_rcvd), .req_dir_in(req_dir_in),
    .req_len_zero(req_len_zero), .cause_en(cause_en), .cause_clr(cause_clr),
    .stage(stage), .stall_req(stall_req), .cause_sts(cause_sts), .irq(irq)
  );

  // Behavioural reference: stage as an integer, flags as bits.
  int m_stage, m_dst, m_dest;
  bit m_hs, m_moved, m_first, m_defer, m_stall, m_err;
  bit [4:0] m_sts, m_ev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stage = 0; m_dst = 0; m_hs = 0; m_moved = 0; m_first = 0;
      m_defer = 0; m_stall = 0; m_sts = 0;
    end else begin
      m_ev = 0; m_err = 0;
      if (req_len_zero) m_dest = 5; else if (req_dir_in) m_dest = 1; else m_dest = 3;
      if (tok_setup) begin
        m_hs = 1; m_stall = 0; m_defer = 0;
        if (m_stage != 6) m_stage = 0;
      end else if (m_hs && hs_ack_sent) begin
        m_hs = 0; m_moved = 0; m_first = 0;
        if (m_stage == 6) begin m_defer = 1; m_dst = m_dest; end
        else begin m_stage = m_dest; m_ev[0] = 1; end
      end else if (m_stage == 6) begin
        if (cause_clr[4]) begin
          if (m_defer) begin m_stage = m_dst; m_ev[0] = 1; end else m_stage = 0;
          m_defer = 0;
        end
      end else if (m_stage == 1) begin
        if (tok_out || tok_ping) begin
          if (m_moved) begin m_stage = 2; m_ev[1] = 1; end else m_err = 1;
        end else if (hs_ack_rcvd) m_moved = 1;
      end else if (m_stage == 2) begin
        if (tok_in || (pkt_rx && !pkt_pid1)) m_err = 1;
        else if (hs_ack_sent) begin m_stage = 0; m_ev[3] = 1; end
      end else if (m_stage == 3) begin
        if (tok_in) begin
          if (m_moved) begin m_stage = 4; m_ev[2] = 1; end else m_err = 1;
        end else begin
          if (pkt_rx) begin
            if (!m_first && !pkt_pid1) m_err = 1;
            m_first = 1;
          end
          if (hs_ack_sent) m_moved = 1;
        end
      end else if (m_stage == 4 || m_stage == 5) begin
        if (tok_out || tok_ping) m_err = 1;
        else if (hs_ack_rcvd) begin m_stage = 0; m_ev[3] = 1; end
      end
      if (m_err) begin m_stage = 6; m_stall = 1; m_ev[4] = 1; end
      m_sts = (m_sts & ~cause_clr) | m_ev;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      chk("R1 stage vs model", int'(stage), m_stage);
      chk("R8 stall vs model", int'(stall_req), int'(m_stall));
      chk("R13 status vs model", int'(cause_sts), int'(m_sts));
      chk("R13 irq vs model", int'(irq), int'(|(m_sts & cause_en)));
    end
  end

  localparam int P_SETUP = 0, P_IN = 1, P_OUT = 2, P_PING = 3,
                 P_D0 = 4, P_D1 = 5, P_ATX = 6, P_ARX = 7;

  task automatic pulse(input int k);
    case (k)
      P_SETUP: tok_setup = 1;
      P_IN:    tok_in = 1;
      P_OUT:   tok_out = 1;
      P_PING:  tok_ping = 1;
      P_D0:    begin pkt_rx = 1; pkt_pid1 = 0; end
      P_D1:    begin pkt_rx = 1; pkt_pid1 = 1; end
      P_ATX:   hs_ack_sent = 1;
      default: hs_ack_rcvd = 1;
    endcase
    @(negedge clk);
    tok_setup = 0; tok_in = 0; tok_out = 0; tok_ping = 0;
    pkt_rx = 0; pkt_pid1 = 0; hs_ack_sent = 0; hs_ack_rcvd = 0;
  endtask

  task automatic clear(input logic [4:0] m);
    cause_clr = m;
    @(negedge clk);
    cause_clr = 0;
  endtask

  task automatic start(input logic dir, input logic lz);
    req_dir_in = dir; req_len_zero = lz;
    pulse(P_SETUP);
    pulse(P_ATX);
  endtask

  task automatic expect_err(input string req);
    chk(req, int'(stage), 6);
    chk(req, int'(stall_req), 1);
    chk(req, int'(cause_sts[4]), 1);
    clear(5'h1f);
    chk("R9 clear returns idle", int'(stage), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0;
    tok_setup = 0; tok_in = 0; tok_out = 0; tok_ping = 0; pkt_rx = 0; pkt_pid1 = 0;
    hs_ack_sent = 0; hs_ack_rcvd = 0; req_dir_in = 0; req_len_zero = 0;
    cause_en = 5'h1f; cause_clr = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset stage", int'(stage), 0);
    chk("R1 reset stall", int'(stall_req), 0);
    chk("R1 reset status", int'(cause_sts), 0);
    rst_n = 1; live = 1;
    @(negedge clk);

    // Control read
    req_dir_in = 1; req_len_zero = 0;
    pulse(P_SETUP);
    chk("R2 setup stage", int'(stage), 0);
    pulse(P_ATX);
    chk("R2 read data entry", int'(stage), 1);
    chk("R2 setup done bit", int'(cause_sts[0]), 1);
    pulse(P_IN); pulse(P_ARX); pulse(P_IN); pulse(P_ARX);
    pulse(P_OUT);
    chk("R3 read status entry", int'(stage), 2);
    chk("R3 read status bit", int'(cause_sts[1]), 1);
    pulse(P_D1);
    chk("R11 long DATA1 in status", int'(stage), 2);
    pulse(P_ATX);
    chk("R4 read complete", int'(stage), 0);
    chk("R4 complete bit", int'(cause_sts[3]), 1);
    clear(5'h1f);

    // Read with PING as status token
    start(1, 0);
    pulse(P_IN); pulse(P_ARX); pulse(P_PING);
    chk("R3 ping enters read status", int'(stage), 2);
    pulse(P_ATX);
    clear(5'h1f);

    // Control write, extra packets with both PIDs
    start(0, 0);
    chk("R2 write data entry", int'(stage), 3);
    pulse(P_D1); pulse(P_ATX);
    pulse(P_D0); pulse(P_ATX);
    pulse(P_D1); pulse(P_ATX);
    pulse(P_D0); pulse(P_ATX);
    chk("R10 extra write data no error", int'(stage), 3);
    chk("R10 no stall", int'(stall_req), 0);
    pulse(P_IN);
    chk("R3 write status entry", int'(stage), 4);
    chk("R3 write status bit", int'(cause_sts[2]), 1);
    pulse(P_ARX);
    chk("R4 write complete", int'(stage), 0);
    clear(5'h1f);

    // No-data
    start(0, 1);
    chk("R2 no-data entry", int'(stage), 5);
    pulse(P_IN); pulse(P_ARX);
    chk("R4 no-data complete", int'(stage), 0);
    clear(5'h1f);
    start(1, 1);
    chk("R2 no-data wins over direction", int'(stage), 5);
    pulse(P_IN); pulse(P_ARX);
    clear(5'h1f);

    // Read errors
    start(1, 0); pulse(P_OUT); expect_err("R5 OUT before data");
    start(1, 0); pulse(P_IN); pulse(P_PING); expect_err("R5 PING before ACK");
    start(1, 0); pulse(P_IN); pulse(P_ARX); pulse(P_OUT); pulse(P_IN);
    expect_err("R5 IN in read status");
    start(1, 0); pulse(P_IN); pulse(P_ARX); pulse(P_OUT); pulse(P_D0);
    expect_err("R5 DATA0 in read status");

    // Write errors
    start(0, 0); pulse(P_D1); pulse(P_IN); expect_err("R6 IN before ACK");
    start(0, 0); pulse(P_D0); expect_err("R6 first DATA0");
    start(0, 0); pulse(P_D1); pulse(P_ATX); pulse(P_IN); pulse(P_OUT);
    expect_err("R6 OUT in write status");
    start(0, 0); pulse(P_D1); pulse(P_ATX); pulse(P_IN); pulse(P_PING);
    expect_err("R6 PING in write status");

    // No-data errors
    start(0, 1); pulse(P_OUT); expect_err("R7 OUT in no-data status");
    start(0, 1); pulse(P_PING); expect_err("R7 PING in no-data status");

    // Deferred setup while error held
    start(0, 1); pulse(P_OUT);
    clear(5'h0f);
    chk("R9 held after other clears", int'(stage), 6);
    req_dir_in = 1; req_len_zero = 0;
    pulse(P_SETUP);
    chk("R12 setup drops stall", int'(stall_req), 0);
    chk("R9 stays error on setup", int'(stage), 6);
    pulse(P_ATX);
    chk("R9 held after setup ack", int'(stage), 6);
    chk("R9 setup done deferred", int'(cause_sts[0]), 0);
    pulse(P_IN);
    chk("R9 tokens ignored while held", int'(stage), 6);
    clear(5'h10);
    chk("R9 deferred destination", int'(stage), 1);
    chk("R9 deferred setup done", int'(cause_sts[0]), 1);
    clear(5'h1f);

    // Abort by SETUP
    pulse(P_SETUP);
    chk("R12 abort to idle", int'(stage), 0);
    pulse(P_ATX);
    pulse(P_IN); pulse(P_ARX); pulse(P_OUT);
    pulse(P_SETUP);
    chk("R12 abort from status", int'(stage), 0);
    clear(5'h1f);

    // Enables
    cause_en = 0;
    start(0, 0);
    chk("R13 status without enable", int'(cause_sts[0]), 1);
    chk("R13 irq masked", int'(irq), 0);
    cause_en = 5'h01;
    @(negedge clk);
    chk("R13 irq enabled", int'(irq), 1);
    cause_en = 5'h1e;
    @(negedge clk);
    chk("R13 irq other bits", int'(irq), 0);
    cause_clr = 5'h01; tok_setup = 1;
    @(negedge clk);
    cause_clr = 0; tok_setup = 0;
    chk("R13 clear applied", int'(cause_sts[0]), 0);
    pulse(P_ATX);
    cause_clr = 5'h01;
    @(negedge clk);
    cause_clr = 0;
    cause_en = 5'h1f;
    @(negedge clk);

    live = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule